// File: doc/BRIEF.md
# Lane Endpoint Resolver

This block turns a packed lane address into the two positions an atom travels between. A request carries two 32-bit words. The first word gives the word index and the site index of the lane's forward-source position. The second word gives the travel direction, the kind of bus (a bus that moves atoms between sites in the same word, or a bus that moves atoms between words at the same site) and the bus number. The block looks up the chosen bus in a table it holds in registers. It walks the bus entries one per cycle until an entry's source matches. It then returns the source and destination positions, or an error code, on a response channel.

The encoded position is always the forward source. A backward lane therefore resolves to the same pair of positions as the forward lane, with source and destination exchanged. Every check, including the source match, uses the forward source and ignores the direction bit.

Requests and responses each use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is being searched and no response is waiting. A response is offered with `rsp_valid`. The response and all of its fields hold still until a clock edge where `rsp_ready` is high. The block accepts no new request until that edge has passed. The bus table and the two membership bitmaps are loaded through a plain write port, which is usable at any time.

Top module: `lane_resolver`

## Requirements
- R1: Request word `req_addr_lo` carries the word index in bits 31..16 and the site index in bits 15..0. In `req_addr_hi`, bit 31 is the direction (0 forward, 1 backward), bit 30 is the bus kind (0 site bus, 1 word bus), bits 15..0 are the bus number, and bits 29..16 are ignored.
- R2: For a site bus, the first valid entry whose source equals the site index gives the forward destination: the same word, and the site taken from that entry's destination.
- R3: For a word bus, the first valid entry whose source equals the word index gives the forward destination: the word taken from that entry's destination, and the same site.
- R4: With the direction bit at 1, the response swaps the forward source and the forward destination. With the direction bit at 0, it gives them unchanged.
- R5: `rsp_err` codes are 0 ok, 1 bus number out of range, 2 word index out of range, 3 site index out of range, 4 not a member, 5 no matching source. When several faults apply, the lowest code among them is reported. On any error all four position outputs are zero.
- R6: The bus number is out of range when it is not below the bus count for its own kind: `N_SITE_BUS` for site buses, `N_WORD_BUS` for word buses. The word index is out of range at or above `WORD_CNT`, and the site index at or above `SITE_CNT`.
- R7: A site-bus lane needs its word's bit set in the site-bus word bitmap. A word-bus lane needs its site's bit set in the word-bus site bitmap.
- R8: When no valid entry of the bus matches the forward source, the error is code 5. This holds even when the position appears among the bus destinations, and it does not depend on the direction bit.
- R9: Counting the accepting edge as edge 1, `rsp_valid` rises after edge 1 for codes 1 to 4, after edge i+2 for a match at entry i, and after edge `BUS_LEN`+1 for code 5. `req_ready` and `rsp_valid` are never high together.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and every response field stay unchanged. A request presented during that time is taken only after the response handshake.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0, every bus entry is invalid and both bitmaps are clear.
- R12: When `cfg_we` is high, `cfg_kind` selects the write. Kind 0 writes site-bus entry (`cfg_bus`, `cfg_idx`) and kind 1 writes word-bus entry (`cfg_bus`, `cfg_idx`). For both, the source comes from `cfg_data[31:16]`, the destination from `cfg_data[15:0]`, and the entry is marked valid. Kind 2 loads the site-bus word bitmap and kind 3 loads the word-bus site bitmap, each from the low bits of `cfg_data`. A later write replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | Write target: 0 site entry, 1 word entry, 2 site-bus word bitmap, 3 word-bus site bitmap |
| cfg_bus | input | BSW | Bus number for entry writes |
| cfg_idx | input | IW | Entry index for entry writes |
| cfg_data | input | 32 | Entry {src,dst} or bitmap |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr_lo | input | 32 | Word and site index |
| req_addr_hi | input | 32 | Direction, bus kind, bus number |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response can be taken |
| rsp_src_word | output | 16 | Resolved source word |
| rsp_src_site | output | 16 | Resolved source site |
| rsp_dst_word | output | 16 | Resolved destination word |
| rsp_dst_site | output | 16 | Resolved destination site |
| rsp_err | output | 3 | Error code |

## Verification
Two things can coincide at the request boundary: a response stalled by a low `rsp_ready`, and a new request arriving while that response waits. The bench holds `rsp_ready` low over several cycles with a second request already presented. It checks that the pending response stays frozen and that `req_ready` stays low. It then releases the stall and checks that the second request is taken only afterwards and that it resolves to its own correct endpoints. Separately, several vectors carry more than one fault at once, so that the priority order of the error codes is checked.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [2:0] {
    E_NONE   = 3'd0,
    E_BUS    = 3'd1,
    E_WORD   = 3'd2,
    E_SITE   = 3'd3,
    E_MEMBER = 3'd4,
    E_NOSRC  = 3'd5
  } lane_err_e;

  typedef struct packed {
    logic        vld;
    logic [15:0] src;
    logic [15:0] dst;
  } bus_ent_t;

  localparam logic [1:0] K_SITE_ENT = 2'd0;
  localparam logic [1:0] K_WORD_ENT = 2'd1;
  localparam logic [1:0] K_SB_WORDS = 2'd2;
  localparam logic [1:0] K_WB_SITES = 2'd3;
endpackage

// File: rtl/lane_bus_table.sv
module lane_bus_table
  import lane_pkg::*;
#(
  parameter int N_SITE_BUS = 2,
  parameter int N_WORD_BUS = 3,
  parameter int BUS_LEN    = 5,
  parameter int WORD_CNT   = 16,
  parameter int SITE_CNT   = 16,
  parameter int BSW        = 2,
  parameter int IW         = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [BSW-1:0]      cfg_bus,
  input  logic [IW-1:0]       cfg_idx,
  input  logic [31:0]         cfg_data,
  input  logic                rd_mt,
  input  logic [BSW-1:0]      rd_bus,
  input  logic [IW-1:0]       rd_idx,
  output bus_ent_t            rd_ent,
  output logic [WORD_CNT-1:0] sb_words,
  output logic [SITE_CNT-1:0] wb_sites
);
  bus_ent_t site_q [N_SITE_BUS][BUS_LEN];
  bus_ent_t word_q [N_WORD_BUS][BUS_LEN];

  logic idx_ok;
  assign idx_ok = int'(cfg_idx) < BUS_LEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_SITE_BUS; b++)
        for (int i = 0; i < BUS_LEN; i++) site_q[b][i] <= '0;
      for (int b = 0; b < N_WORD_BUS; b++)
        for (int i = 0; i < BUS_LEN; i++) word_q[b][i] <= '0;
      sb_words <= '0;
      wb_sites <= '0;
    end else if (cfg_we) begin
      case (cfg_kind)
        K_SITE_ENT:
          if (idx_ok && int'(cfg_bus) < N_SITE_BUS)
            site_q[cfg_bus][cfg_idx] <= '{vld: 1'b1, src: cfg_data[31:16], dst: cfg_data[15:0]};
        K_WORD_ENT:
          if (idx_ok && int'(cfg_bus) < N_WORD_BUS)
            word_q[cfg_bus][cfg_idx] <= '{vld: 1'b1, src: cfg_data[31:16], dst: cfg_data[15:0]};
        K_SB_WORDS: sb_words <= cfg_data[WORD_CNT-1:0];
        default:    wb_sites <= cfg_data[SITE_CNT-1:0];
      endcase
    end
  end

  always_comb begin
    rd_ent = '0;
    if (rd_mt) begin
      if (int'(rd_bus) < N_WORD_BUS) rd_ent = word_q[rd_bus][rd_idx];
    end else begin
      if (int'(rd_bus) < N_SITE_BUS) rd_ent = site_q[rd_bus][rd_idx];
    end
  end

  assert_bitmap_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_kind == K_SB_WORDS |=> sb_words == $past(cfg_data[WORD_CNT-1:0]));
  assert_entry_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_kind == K_SITE_ENT && idx_ok && int'(cfg_bus) < N_SITE_BUS
    |=> site_q[$past(cfg_bus)][$past(cfg_idx)].vld);
endmodule

// File: rtl/lane_pre_check.sv
module lane_pre_check
  import lane_pkg::*;
#(
  parameter int N_SITE_BUS = 2,
  parameter int N_WORD_BUS = 3,
  parameter int WORD_CNT   = 16,
  parameter int SITE_CNT   = 16
) (
  input  logic [15:0]         word_id,
  input  logic [15:0]         site_id,
  input  logic                mt,
  input  logic [15:0]         bus_id,
  input  logic [WORD_CNT-1:0] sb_words,
  input  logic [SITE_CNT-1:0] wb_sites,
  output lane_err_e           err
);
  localparam int WW = (WORD_CNT > 1) ? $clog2(WORD_CNT) : 1;
  localparam int SW = (SITE_CNT > 1) ? $clog2(SITE_CNT) : 1;

  logic bus_bad, member_ok;
  assign bus_bad   = mt ? (bus_id >= 16'(N_WORD_BUS)) : (bus_id >= 16'(N_SITE_BUS));
  assign member_ok = mt ? wb_sites[site_id[SW-1:0]] : sb_words[word_id[WW-1:0]];

  always_comb begin
    if (bus_bad)                        err = E_BUS;
    else if (word_id >= 16'(WORD_CNT))  err = E_WORD;
    else if (site_id >= 16'(SITE_CNT))  err = E_SITE;
    else if (!member_ok)                err = E_MEMBER;
    else                                err = E_NONE;
  end
endmodule

// File: rtl/lane_resolver.sv
module lane_resolver
  import lane_pkg::*;
#(
  parameter int N_SITE_BUS = 2,
  parameter int N_WORD_BUS = 3,
  parameter int BUS_LEN    = 5,
  parameter int WORD_CNT   = 16,
  parameter int SITE_CNT   = 16,
  localparam int NB_MAX    = (N_SITE_BUS > N_WORD_BUS) ? N_SITE_BUS : N_WORD_BUS,
  localparam int BSW       = (NB_MAX > 1) ? $clog2(NB_MAX) : 1,
  localparam int IW        = (BUS_LEN > 1) ? $clog2(BUS_LEN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_kind,
  input  logic [BSW-1:0] cfg_bus,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [31:0]    cfg_data,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [31:0]    req_addr_lo,
  input  logic [31:0]    req_addr_hi,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [15:0]    rsp_src_word,
  output logic [15:0]    rsp_src_site,
  output logic [15:0]    rsp_dst_word,
  output logic [15:0]    rsp_dst_site,
  output logic [2:0]     rsp_err
);
  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_DONE} st_e;

  st_e            st;
  logic [15:0]    w_q, s_q;
  logic           dir_q, mt_q;
  logic [BSW-1:0] bus_q;
  logic [IW-1:0]  idx_q;
  lane_err_e      err_q, pre_err;
  bus_ent_t       ent;
  logic [WORD_CNT-1:0] sb_words;
  logic [SITE_CNT-1:0] wb_sites;
  logic           unused_pad;

  assign unused_pad = ^req_addr_hi[29:16];

  lane_bus_table #(
    .N_SITE_BUS(N_SITE_BUS), .N_WORD_BUS(N_WORD_BUS), .BUS_LEN(BUS_LEN),
    .WORD_CNT(WORD_CNT), .SITE_CNT(SITE_CNT), .BSW(BSW), .IW(IW)
  ) i_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_bus(cfg_bus), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_mt(mt_q), .rd_bus(bus_q), .rd_idx(idx_q), .rd_ent(ent),
    .sb_words(sb_words), .wb_sites(wb_sites)
  );

  lane_pre_check #(
    .N_SITE_BUS(N_SITE_BUS), .N_WORD_BUS(N_WORD_BUS),
    .WORD_CNT(WORD_CNT), .SITE_CNT(SITE_CNT)
  ) i_check (
    .word_id(req_addr_lo[31:16]), .site_id(req_addr_lo[15:0]),
    .mt(req_addr_hi[30]), .bus_id(req_addr_hi[15:0]),
    .sb_words(sb_words), .wb_sites(wb_sites), .err(pre_err)
  );

  logic [15:0] key, fdw, fds;
  logic        hit;
  assign key = mt_q ? w_q : s_q;
  assign hit = ent.vld && (ent.src == key);
  assign fdw = mt_q ? ent.dst : w_q;
  assign fds = mt_q ? s_q : ent.dst;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; w_q <= '0; s_q <= '0; dir_q <= 1'b0; mt_q <= 1'b0;
      bus_q <= '0; idx_q <= '0; err_q <= E_NONE;
      rsp_src_word <= '0; rsp_src_site <= '0; rsp_dst_word <= '0; rsp_dst_site <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          w_q   <= req_addr_lo[31:16];
          s_q   <= req_addr_lo[15:0];
          dir_q <= req_addr_hi[31];
          mt_q  <= req_addr_hi[30];
          bus_q <= req_addr_hi[BSW-1:0];
          idx_q <= '0;
          rsp_src_word <= '0; rsp_src_site <= '0; rsp_dst_word <= '0; rsp_dst_site <= '0;
          err_q <= pre_err;
          st    <= (pre_err == E_NONE) ? S_SEARCH : S_DONE;
        end
        S_SEARCH: begin
          if (hit) begin
            err_q <= E_NONE;
            if (dir_q) begin
              rsp_src_word <= fdw; rsp_src_site <= fds;
              rsp_dst_word <= w_q; rsp_dst_site <= s_q;
            end else begin
              rsp_src_word <= w_q; rsp_src_site <= s_q;
              rsp_dst_word <= fdw; rsp_dst_site <= fds;
            end
            st <= S_DONE;
          end else if (int'(idx_q) == BUS_LEN - 1) begin
            err_q <= E_NOSRC;
            st    <= S_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_src_word, rsp_src_site, rsp_dst_word, rsp_dst_site, rsp_err}));
  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  assert_zero_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err != 3'd0 |->
      {rsp_src_word, rsp_src_site, rsp_dst_word, rsp_dst_site} == '0);
  assert_forward_keeps_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err == 3'd0 && !dir_q |-> rsp_src_word == w_q && rsp_src_site == s_q);
  assert_backward_lands_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err == 3'd0 && dir_q |-> rsp_dst_word == w_q && rsp_dst_site == s_q);
  assert_index_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SEARCH |-> int'(idx_q) < BUS_LEN);
endmodule

// File: tb/test_lane_resolver.sv
`timescale 1ns/1ps
module test_lane_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_kind;
  logic [1:0]  cfg_bus;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_data;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [31:0] req_addr_lo, req_addr_hi;
  logic [15:0] sw, ss, dw, ds;
  logic [2:0]  err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lane_resolver i_lane_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_bus(cfg_bus), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_src_word(sw), .rsp_src_site(ss), .rsp_dst_word(dw), .rsp_dst_site(ds),
    .rsp_err(err)
  );

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [2:0]  err;
    logic [15:0] sw, ss, dw, ds;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0000, 32'h0000_0000, 3'd0, 16'd1, 16'd0, 16'd1, 16'd5, 8'd2},  // R2 entry0
    '{32'h0001_0002, 32'h8000_0000, 3'd0, 16'd1, 16'd7, 16'd1, 16'd2, 8'd4},  // R4 backward
    '{32'h0003_0004, 32'h0000_0000, 3'd0, 16'd3, 16'd4, 16'd3, 16'd9, 8'd6},  // R9 last entry
    '{32'h0002_000B, 32'h0000_0001, 3'd0, 16'd2, 16'd11, 16'd2, 16'd13, 8'd3}, // R2 bus1
    '{32'h0002_0005, 32'h4000_0000, 3'd0, 16'd2, 16'd5, 16'd10, 16'd5, 8'd4}, // R3
    '{32'h0000_0007, 32'hC000_0000, 3'd0, 16'd8, 16'd7, 16'd0, 16'd7, 8'd2},  // R3 R4 backward
    '{32'h0003_0001, 32'h4000_0001, 3'd0, 16'd3, 16'd1, 16'd4, 16'd1, 8'd4},  // R3 skip invalid
    '{32'h0014_001E, 32'h0000_0002, 3'd1, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R5 R6 bus first
    '{32'h0001_0001, 32'h4000_0003, 3'd1, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R6 word-bus range
    '{32'h0001_0001, 32'h4000_0002, 3'd5, 16'd0, 16'd0, 16'd0, 16'd0, 8'd6},  // R6 R8 empty bus
    '{32'h0010_0010, 32'h0000_0000, 3'd2, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R5 word before site
    '{32'h0001_0010, 32'h0000_0000, 3'd3, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R6 site range
    '{32'h0005_0009, 32'h0000_0000, 3'd4, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R7 R5 member first
    '{32'h0000_0009, 32'h4000_0000, 3'd4, 16'd0, 16'd0, 16'd0, 16'd0, 8'd1},  // R7 word bus
    '{32'h0001_0005, 32'h0000_0000, 3'd5, 16'd0, 16'd0, 16'd0, 16'd0, 8'd6},  // R8
    '{32'h0001_0007, 32'h8000_0000, 3'd5, 16'd0, 16'd0, 16'd0, 16'd0, 8'd6},  // R8 backward
    '{32'h0001_0001, 32'h3FFF_0000, 3'd0, 16'd1, 16'd1, 16'd1, 16'd6, 8'd3},  // R1 pad ignored
    '{32'h0000_0003, 32'h4000_0001, 3'd5, 16'd0, 16'd0, 16'd0, 16'd0, 8'd6}   // R3 R8 key is word
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [1:0] b, input logic [2:0] i,
                    input logic [31:0] d);
    cfg_we = 1'b1; cfg_kind = k; cfg_bus = b; cfg_idx = i; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] lo, input logic [31:0] hi, output int lat);
    req_addr_lo = lo; req_addr_hi = hi; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic compare(input string req, input vec_t v, input int lat);
    chk({req, " err"}, 64'(err), 64'(v.err));
    chk({req, " pos"}, {sw, ss, dw, ds}, {v.sw, v.ss, v.dw, v.ds});
    chk({req, " latency"}, 64'(lat), 64'(v.lat));
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    vec_t v2;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = '0; cfg_bus = '0; cfg_idx = '0; cfg_data = '0;
    req_valid = 1'b0; rsp_ready = 1'b1; req_addr_lo = '0; req_addr_hi = '0;
    repeat (3) @(negedge clk);
    chk("R11 req_ready", 64'(req_ready), 64'd1);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: bitmaps clear after reset, so a well-formed lane is not a member
    run(32'h0000_0000, 32'h0000_0000, lat);
    chk("R11 empty bitmap err", 64'(err), 64'd4);
    @(negedge clk);
    // R12: give membership, table still empty -> no source
    wr(2'd2, 2'd0, 3'd0, 32'h0000_000F);
    run(32'h0000_0000, 32'h0000_0000, lat);
    chk("R11 empty table err", 64'(err), 64'd5);
    @(negedge clk);

    for (int i = 0; i < 5; i++) wr(2'd0, 2'd0, 3'(i), {16'(i), 16'(i + 5)});
    wr(2'd0, 2'd1, 3'd0, {16'd10, 16'd12});
    wr(2'd0, 2'd1, 3'd1, {16'd11, 16'd13});
    wr(2'd1, 2'd0, 3'd0, {16'd0, 16'd8});
    wr(2'd1, 2'd0, 3'd1, {16'd1, 16'd9});
    wr(2'd1, 2'd0, 3'd2, {16'd2, 16'd10});
    wr(2'd1, 2'd1, 3'd2, {16'd3, 16'd4});
    wr(2'd3, 2'd0, 3'd0, 32'h0000_00FF);

    for (int i = 0; i < NV; i++) begin
      chk("R9 idle ready", 64'(req_ready), 64'd1);
      run(VECS[i].lo, VECS[i].hi, lat);
      compare($sformatf("R1-vec%0d", i), VECS[i], lat);
      @(negedge clk);
    end

    // R12: overwrite site bus 1 entry 1 with a new destination
    wr(2'd0, 2'd1, 3'd1, {16'd11, 16'd14});
    run(32'h0002_000B, 32'h0000_0001, lat);
    chk("R12 overwrite dst", {dw, ds}, {16'd2, 16'd14});
    @(negedge clk);

    // R10: stall a response while the next request waits
    rsp_ready = 1'b0;
    run(32'h0001_0000, 32'h0000_0000, lat);
    req_addr_lo = 32'h0002_0005; req_addr_hi = 32'h4000_0000; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 still valid", 64'(rsp_valid), 64'd1);
    chk("R10 held fields", {sw, ss, dw, ds}, {16'd1, 16'd0, 16'd1, 16'd5});
    chk("R10 not ready", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 idle after handshake", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    v2 = VECS[4];
    compare("R10 queued request", v2, lat);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule